// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block counts main-clock cycles and raises a system reset request when software fails to service it within the selected timeout. Servicing takes an ordered pair of writes to one service port. The first write carries an arm key, 0x55. The second carries a clear key, 0xAA, and only that key, given while armed, restarts the count. A single stray write cannot keep a runaway program alive.

Two inputs are latched while reset is held: a disable bit, normally driven from a nonvolatile configuration cell, and a 2-bit rate select. Once reset is released they are frozen. A timeout produces one reset-request pulse of fixed length. After the pulse the count starts again from zero. The count advances only on the main clock, so the block cannot detect a clock that has stopped.

Top module: `keyed_watchdog`

## Requirements
- R1: When `cfg_off` is 1 while reset is held, the block never raises `rst_req`, and service writes have no visible effect.
- R2: The timeout length is L = 2^BASE_LOG2 × 4^`rate_sel`. `rate_sel` = 0, 1, 2, 3 selects ×1, ×4, ×16, ×64. `rst_req` goes high after L clock edges, counted from the reset release or from the clear write, whichever was last.
- R3: A write (`svc_wr`=1) with `svc_data` = 0x55 arms the clearing mechanism.
- R4: A write of 0xAA while armed restarts the count from zero and disarms the block.
- R5: A write of 0xAA while not armed has no effect on the count or on the armed state.
- R6: A write of any value other than the two keys leaves the armed state unchanged. A repeated 0x55 also leaves the block armed.
- R7: A timeout drives `rst_req` high for exactly PULSE_LEN cycles. The count restarts from zero when the pulse ends, so the next pulse begins L edges after the previous one falls.
- R8: `cfg_off` and `rate_sel` are sampled only while `rst_n` is low. Changes after release have no effect.
- R9: A timeout disarms the block, so a later 0xAA with no new 0x55 does not clear the count.
- R10: `rst_req` is low while reset is held and in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; also the count source |
| rst_n | input | 1 | Synchronous active-low reset; configuration is latched while it is low |
| cfg_off | input | 1 | Disable bit from configuration storage (1 = watchdog off) |
| rate_sel | input | 2 | Timeout multiplier select (×1, ×4, ×16, ×64) |
| svc_wr | input | 1 | Service-port write strobe |
| svc_data | input | 8 | Service-port write data (keys) |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench goes after key-ordering mistakes. If the block accepted 0xAA unarmed, the clear-before-arm vector would time out late. If stray values dropped the armed state, the arm/other/clear sequence would not clear. A block that kept the armed state through a timeout would let a lone 0xAA postpone the next pulse. Further checks change `rate_sel` and `cfg_off` after release, where a block that failed to freeze them would time out at the wrong edge or would not stay quiet. The checks also measure the exact pulse width and the gap from the end of one pulse to the start of the next, which exposes an off-by-one in the count restart.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef logic [1:0] rate_t;

  // Timeout length in clocks: base period scaled by 4^rate.
  function automatic logic [31:0] wd_limit(input rate_t rate, input int unsigned base_log2);
    int unsigned sh;
    sh = base_log2 + 2 * int'(rate);
    return 32'd1 << sh;
  endfunction

endpackage

// File: rtl/wd_cfg_latch.sv
module wd_cfg_latch (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_off,
  input  wd_pkg::rate_t rate_sel,
  output logic          run_q,
  output wd_pkg::rate_t rate_q
);
  // Configuration is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= ~cfg_off;
      rate_q <= rate_sel;
    end
  end
endmodule

// File: rtl/wd_key_seq.sv
module wd_key_seq #(
  parameter logic [7:0] ARM_KEY = 8'h55,
  parameter logic [7:0] CLR_KEY = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       wr,
  input  logic [7:0] data,
  input  logic       disarm,
  output logic       armed,
  output logic       clr_evt
);
  logic arm_hit;

  assign arm_hit = run & wr & (data == ARM_KEY);
  assign clr_evt = run & wr & (data == CLR_KEY) & armed;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) armed <= 1'b0;
    else if (clr_evt)   armed <= 1'b0;
    else if (disarm)    armed <= 1'b0;
    else if (arm_hit)   armed <= 1'b1;
  end
endmodule

// File: rtl/wd_timebase.sv
module wd_timebase #(
  parameter int BASE_LOG2 = 15,
  localparam int CW = BASE_LOG2 + 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  wd_pkg::rate_t rate,
  input  logic          clr,
  input  logic          hold,
  output logic [CW-1:0] cnt,
  output logic          timeout_evt
);
  logic [CW-1:0] term;

  assign term        = CW'(wd_pkg::wd_limit(rate, BASE_LOG2) - 32'd1);
  assign timeout_evt = run & ~hold & ~clr & (cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)              cnt <= '0;
    else if (clr || hold || timeout_evt) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wd_pulse.sv
module wd_pulse #(
  parameter int PULSE_LEN = 16,
  localparam int PW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  logic [PW-1:0] left;

  assign busy = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    left <= '0;
    else if (fire) left <= PW'(PULSE_LEN);
    else if (busy) left <= left - 1'b1;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int         BASE_LOG2 = 15,
  parameter int         PULSE_LEN = 16,
  parameter logic [7:0] ARM_KEY   = 8'h55,
  parameter logic [7:0] CLR_KEY   = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_off,
  input  logic [1:0] rate_sel,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       rst_req
);
  localparam int CW = BASE_LOG2 + 6;

  logic          run_q;
  wd_pkg::rate_t rate_q;
  logic          armed;
  logic          clr_evt;
  logic          timeout_evt;
  logic [CW-1:0] cnt;

  wd_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .rate_sel(rate_sel),
    .run_q(run_q), .rate_q(rate_q)
  );

  wd_key_seq #(.ARM_KEY(ARM_KEY), .CLR_KEY(CLR_KEY)) u_keys (
    .clk(clk), .rst_n(rst_n), .run(run_q), .wr(svc_wr), .data(svc_data),
    .disarm(timeout_evt), .armed(armed), .clr_evt(clr_evt)
  );

  wd_timebase #(.BASE_LOG2(BASE_LOG2)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run_q), .rate(rate_q), .clr(clr_evt),
    .hold(rst_req), .cnt(cnt), .timeout_evt(timeout_evt)
  );

  wd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(timeout_evt), .busy(rst_req)
  );
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
  parameter int         CW        = 21,
  parameter int         PULSE_LEN = 16,
  parameter logic [7:0] ARM_KEY   = 8'h55,
  parameter logic [7:0] CLR_KEY   = 8'hAA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_q,
  input logic [1:0]    rate_q,
  input logic          svc_wr,
  input logic [7:0]    svc_data,
  input logic          armed,
  input logic          clr_evt,
  input logic          timeout_evt,
  input logic [CW-1:0] cnt,
  input logic          rst_req
);
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)       hi_run <= '0;
    else if (rst_req) hi_run <= hi_run + 16'd1;
    else              hi_run <= '0;
  end

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !rst_req);

  a_r3_arm_key: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && svc_wr && svc_data == ARM_KEY && !timeout_evt) |=> armed);

  a_r4_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (cnt == '0) && !armed);

  a_r5_unarmed_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && svc_wr && svc_data == CLR_KEY && !armed && !rst_req && !timeout_evt)
      |=> (cnt == CW'($past(cnt) + 1'b1)));

  a_r6_other_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && svc_data != ARM_KEY && svc_data != CLR_KEY && !timeout_evt)
      |=> (armed == $past(armed)));

  a_r7_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= 16'(PULSE_LEN));

  a_r7_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (hi_run == 16'(PULSE_LEN)));

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(rate_q) && $stable(run_q)));

  a_r9_timeout_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (!armed && rst_req));
endmodule

bind keyed_watchdog wd_checker #(
  .CW(CW), .PULSE_LEN(PULSE_LEN), .ARM_KEY(ARM_KEY), .CLR_KEY(CLR_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .rate_q(rate_q),
  .svc_wr(svc_wr), .svc_data(svc_data), .armed(armed), .clr_evt(clr_evt),
  .timeout_evt(timeout_evt), .cnt(cnt), .rst_req(rst_req)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
  localparam int BASE = 4;
  localparam int PLEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_off = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic svc_wr = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic rst_req;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  keyed_watchdog #(.BASE_LOG2(BASE), .PULSE_LEN(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .rate_sel(rate_sel),
    .svc_wr(svc_wr), .svc_data(svc_data), .rst_req(rst_req)
  );

  typedef struct packed {
    logic [1:0]  rate;
    logic [15:0] idle;
    logic [7:0]  k1;
    logic [7:0]  k2;
    logic        clears;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{2'd0, 16'd3,   8'h55, 8'hAA, 1'b1},   // R3 R4 base rate
    '{2'd1, 16'd20,  8'h55, 8'hAA, 1'b1},   // R2 x4
    '{2'd0, 16'd3,   8'hAA, 8'h55, 1'b0},   // R5 wrong order
    '{2'd2, 16'd100, 8'h55, 8'h12, 1'b0},   // R2 x16, no clear key
    '{2'd0, 16'd2,   8'h55, 8'h55, 1'b0},   // R6 repeated arm
    '{2'd3, 16'd500, 8'h55, 8'hAA, 1'b1},   // R2 x64
    '{2'd1, 16'd10,  8'h12, 8'hAA, 1'b0}    // R5 stray then clear
  };

  function automatic int exp_len(input int r);
    int l = 1 << BASE;
    for (int i = 0; i < r; i++) l = l * 4;
    return l;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset(input logic off, input logic [1:0] r);
    @(negedge clk);
    rst_n = 1'b0; cfg_off = off; rate_sel = r; svc_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d, output int at);
    @(negedge clk);
    svc_wr = 1'b1; svc_data = d;
    @(negedge clk);
    svc_wr = 1'b0;
    at = ecount;
  endtask

  task automatic wait_req(output int t);
    int g = 0;
    while (!rst_req && g < 5000) begin
      @(negedge clk);
      g++;
    end
    t = rst_req ? ecount : -1;
  endtask

  task automatic wait_fall(output int t);
    int g = 0;
    while (rst_req && g < 5000) begin
      @(negedge clk);
      g++;
    end
    t = ecount;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      finish_run();
    end
  end

  initial begin
    int w, t, f, seen;

    // R10: reset state
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 low in reset", int'(rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 low after release", int'(rst_req), 0);

    // Vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      do_reset(1'b0, VT[i].rate);
      repeat (int'(VT[i].idle)) @(negedge clk);
      wr(VT[i].k1, w);
      wr(VT[i].k2, w);
      wait_req(t);
      chk($sformatf("R2/R4/R5/R6 vector %0d timeout edge", i), t,
          VT[i].clears ? w + exp_len(int'(VT[i].rate)) : exp_len(int'(VT[i].rate)));
    end

    // R7: pulse width and restart gap
    do_reset(1'b0, 2'd0);
    wait_req(t);
    chk("R2 first timeout", t, exp_len(0));
    wait_fall(f);
    chk("R7 pulse width", f - t, PLEN);
    wait_req(t);
    chk("R7 restart gap", t - f, exp_len(0));

    // R6: stray value keeps armed so the later clear still works
    do_reset(1'b0, 2'd1);
    repeat (4) @(negedge clk);
    wr(8'h55, w);
    wr(8'h3C, w);
    wr(8'hAA, w);
    wait_req(t);
    chk("R6 armed kept through stray value", t, w + exp_len(1));

    // R4: second clear without new arm is ignored
    do_reset(1'b0, 2'd1);
    wr(8'h55, w);
    wr(8'hAA, w);
    f = w;
    repeat (10) @(negedge clk);
    wr(8'hAA, w);
    wait_req(t);
    chk("R4 clear disarms", t, f + exp_len(1));

    // R9: timeout disarms
    do_reset(1'b0, 2'd0);
    repeat (2) @(negedge clk);
    wr(8'h55, w);
    wait_req(t);
    wait_fall(f);
    repeat (3) @(negedge clk);
    wr(8'hAA, w);
    wait_req(t);
    chk("R9 timeout disarms", t, f + exp_len(0));

    // R8: rate change after release ignored
    do_reset(1'b0, 2'd0);
    @(negedge clk);
    rate_sel = 2'd3;
    wait_req(t);
    chk("R8 rate frozen", t, exp_len(0));

    // R1 + R8: disabled, then cfg_off dropped after release
    do_reset(1'b1, 2'd0);
    seen = 0;
    wr(8'h55, w);
    wr(8'hAA, w);
    cfg_off = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
    chk("R1 disabled never requests", seen, 0);
    chk("R8 cfg_off frozen after release", int'(rst_req), 0);

    done = 1;
    finish_run();
  end
endmodule